// File: doc/BRIEF.md
# GPIO Port Configuration Register File

This block is the register file of one 16-pin general-purpose I/O port. A simple 32-bit register bus with word addressing reaches nine registers. Together they hold each pin's mode, output type, slew grade, pull selection and alternate-function number. They also hold the output data latch, show the synchronized pin levels, and offer a write-only set/clear register. Firmware can use that register to change single output bits with no read-modify-write.

Every configuration field goes straight out to the pad ring. The block also resolves, per pin, whether the pad is driven and with what level. In general output mode the level is the output latch bit. In alternate-function mode it is the level that the selected peripheral supplies on `alt_i`. Open-drain pins only ever pull low. The peripheral multiplexer itself sits outside this block; it receives the 4-bit function number of each pin.

The bus carries one access per cycle. A write lands on the rising clock edge. Read data is combinational from `addr_i`.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs with no pull and alternate function 0. `pad_oe_o`, `pad_do_o` and `pad_analog_o` are all 0.
- R2: Word 0 holds a 2-bit mode per pin at bits [2p+1:2p]. The codes are 00 input, 01 general output, 10 alternate function and 11 analog. `pad_analog_o[p]` is 1 exactly when the code is 11. The register reads back what was written.
- R3: Word 1 holds one bit per pin at bit p: 0 selects push-pull, 1 selects open-drain. Bits 31:16 read 0.
- R4: Word 2 (slew grade) and word 3 (pull select) hold 2 bits per pin at [2p+1:2p]. They read back and appear unchanged on `pad_speed_o` and `pad_pull_o`.
- R5: The function number of pin p is 4 bits. Pins 0–7 live in word 7 and pins 8–15 in word 8, each at bit 4·(p mod 8). `pad_af_o[4p+3:4p]` carries pin p's code.
- R6: A write to word 6 sets the output bits whose positions hold ones in wdata[15:0]. It clears those whose positions hold ones in wdata[31:16]. A bit named in both halves ends up set, and unnamed bits keep their value. Word 6 reads 0.
- R7: Word 5 is the output latch. A write replaces all 16 bits, and a read returns them with bits 31:16 zero.
- R8: Word 4 reads the pin levels through a two-flop synchronizer. A level applied before clock edge k is visible after edge k+1, not after edge k. Writes to word 4 change nothing.
- R9: A pin drives (`pad_oe_o`=1) only in mode 01 or 10. Its level is the latch bit in 01 and `alt_i[p]` in 10, shown on `pad_do_o` (0 when not driving). In open-drain type the pin drives only while that level is 0.
- R10: Addresses 9–15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | 16 | Raw pin levels from the pads |
| alt_i | input | 16 | Output level from the selected peripheral, per pin |
| pad_oe_o | output | 16 | Pad output enable |
| pad_do_o | output | 16 | Pad output level |
| pad_analog_o | output | 16 | Pad in analog mode |
| pad_speed_o | output | 32 | Slew grade, 2 bits per pin |
| pad_pull_o | output | 32 | Pull select, 2 bits per pin |
| pad_af_o | output | 64 | Alternate-function number, 4 bits per pin |

## Verification
The assertions assume that `rst_ni` is asserted at start-up. They also assume that bus inputs change only away from the rising edge, so each cycle carries at most one write. The synchronizer check also assumes `pin_i` is a clean level at each sampling edge. The stimulus meets these conditions by driving every input on the falling edge with one access per cycle. For the sake of the model, it holds `pin_i` constant except during the directed synchronizer test.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_MODE   = 4'd0;
  localparam logic [AW-1:0] A_OTYPE  = 4'd1;
  localparam logic [AW-1:0] A_SPEED  = 4'd2;
  localparam logic [AW-1:0] A_PULL   = 4'd3;
  localparam logic [AW-1:0] A_IN     = 4'd4;
  localparam logic [AW-1:0] A_OUT    = 4'd5;
  localparam logic [AW-1:0] A_SETCLR = 4'd6;
  localparam logic [AW-1:0] A_AF_LO  = 4'd7;
  localparam logic [AW-1:0] A_AF_HI  = 4'd8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] in_o
);
  logic [NPIN-1:0] s1_q, s2_q;
  logic [1:0]      warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      warm_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign in_o = s2_q;

  // R8: two-edge latency from pin to visible level
  p_sync_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (in_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [NPIN-1:0] wr_data_i,
  input  logic            sr_en_i,
  input  logic [NPIN-1:0] set_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] out_o
);
  logic [NPIN-1:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (wr_en_i) out_d = wr_data_i;
    if (sr_en_i) out_d = (out_q & ~clr_i) | set_i;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  p_set_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_en_i |=> ((out_q & $past(set_i)) == $past(set_i)));
  p_clr_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_en_i |=> ((out_q & ($past(clr_i) & ~$past(set_i))) == '0));
  p_keep_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_en_i && !wr_en_i) |=>
      (((out_q ^ $past(out_q)) & ~($past(set_i) | $past(clr_i))) == '0));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_en_i && !wr_en_i) |=> $stable(out_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic [2*NPIN-1:0] mode_i,
  input  logic [NPIN-1:0]   otype_i,
  input  logic [NPIN-1:0]   out_i,
  input  logic [NPIN-1:0]   alt_i,
  output logic [NPIN-1:0]   oe_o,
  output logic [NPIN-1:0]   do_o,
  output logic [NPIN-1:0]   analog_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pin_mode_e md;
    logic      drive, lvl;
    assign md          = pin_mode_e'(mode_i[2*p +: 2]);
    assign drive       = (md == PM_OUT) || (md == PM_ALT);
    assign lvl         = (md == PM_ALT) ? alt_i[p] : out_i[p];
    assign do_o[p]     = drive & lvl;
    assign oe_o[p]     = drive & (~otype_i[p] | ~lvl);  // open-drain: low only
    assign analog_o[p] = (md == PM_ANA);

    p_oe_mode_r9: assert final (!oe_o[p] ||
      (mode_i[2*p +: 2] == 2'b01) || (mode_i[2*p +: 2] == 2'b10));
    p_od_low_r9: assert final (!(oe_o[p] && otype_i[p]) || !do_o[p]);
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NPIN-1:0]   alt_i,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_do_o,
  output logic [NPIN-1:0]   pad_analog_o,
  output logic [2*NPIN-1:0] pad_speed_o,
  output logic [2*NPIN-1:0] pad_pull_o,
  output logic [4*NPIN-1:0] pad_af_o
);
  localparam int unsigned FW   = 2 * NPIN;
  localparam int unsigned AFW  = 2 * NPIN;   // 4 bits x NPIN/2 pins per word
  localparam int unsigned PADN = 32 - NPIN;

  logic [FW-1:0]   mode_q, speed_q, pull_q;
  logic [NPIN-1:0] otype_q, out_w, in_w;
  logic [AFW-1:0]  af_lo_q, af_hi_q;
  logic            wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      af_lo_q <= '0;
      af_hi_q <= '0;
    end else if (wr) begin
      case (addr_i)
        A_MODE:  mode_q  <= wdata_i[FW-1:0];
        A_OTYPE: otype_q <= wdata_i[NPIN-1:0];
        A_SPEED: speed_q <= wdata_i[FW-1:0];
        A_PULL:  pull_q  <= wdata_i[FW-1:0];
        A_AF_LO: af_lo_q <= wdata_i[AFW-1:0];
        A_AF_HI: af_hi_q <= wdata_i[AFW-1:0];
        default: ;
      endcase
    end
  end

  gpio_out_data #(.NPIN(NPIN)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr && (addr_i == A_OUT)),
    .wr_data_i (wdata_i[NPIN-1:0]),
    .sr_en_i   (wr && (addr_i == A_SETCLR)),
    .set_i     (wdata_i[NPIN-1:0]),
    .clr_i     (wdata_i[2*NPIN-1:NPIN]),
    .out_o     (out_w)
  );

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .in_o   (in_w)
  );

  gpio_pad_ctrl #(.NPIN(NPIN)) u_pad (
    .mode_i   (mode_q),
    .otype_i  (otype_q),
    .out_i    (out_w),
    .alt_i    (alt_i),
    .oe_o     (pad_oe_o),
    .do_o     (pad_do_o),
    .analog_o (pad_analog_o)
  );

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = 32'(mode_q);
      A_OTYPE: rdata_o = {{PADN{1'b0}}, otype_q};
      A_SPEED: rdata_o = 32'(speed_q);
      A_PULL:  rdata_o = 32'(pull_q);
      A_IN:    rdata_o = {{PADN{1'b0}}, in_w};
      A_OUT:   rdata_o = {{PADN{1'b0}}, out_w};
      A_AF_LO: rdata_o = 32'(af_lo_q);
      A_AF_HI: rdata_o = 32'(af_hi_q);
      default: rdata_o = '0;  // set/clear word and unmapped
    endcase
  end

  assign pad_speed_o = speed_q;
  assign pad_pull_o  = pull_q;
  assign pad_af_o    = {af_hi_q, af_lo_q};

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == A_MODE) |=> $stable(mode_q));
  p_af_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (addr_i == A_AF_LO || addr_i == A_AF_HI)) |=> $stable(pad_af_o));
  p_sr_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SETCLR) |-> (rdata_o == '0));
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i > A_AF_HI) |=> ($stable(mode_q) && $stable(otype_q) &&
      $stable(speed_q) && $stable(pull_q) && $stable(pad_af_o) && $stable(out_w)));
endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;
  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, we_i = 0;
  logic [3:0]  addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic [15:0] pin_i = 0, alt_i = 0;
  logic [15:0] pad_oe_o, pad_do_o, pad_analog_o;
  logic [31:0] pad_speed_o, pad_pull_o;
  logic [63:0] pad_af_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
  logic [15:0] m_otype, m_out;

  always #5 clk_i = ~clk_i;

  gpio_port_regs u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return m_mode;
      4'd1: return {16'h0, m_otype};
      4'd2: return m_speed;
      4'd3: return m_pull;
      4'd4: return {16'h0, pin_i};
      4'd5: return {16'h0, m_out};
      4'd7: return m_aflo;
      4'd8: return m_afhi;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd0: m_mode = d;
      4'd1: m_otype = d[15:0];
      4'd2: m_speed = d;
      4'd3: m_pull = d;
      4'd5: m_out = d[15:0];
      4'd6: m_out = (m_out & ~d[31:16]) | d[15:0];
      4'd7: m_aflo = d;
      4'd8: m_afhi = d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
    model_wr(a, d);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 chk(tag, {32'h0, rdata_o}, {32'h0, exp});
    req_i = 0;
  endtask

  task automatic chk_pads(string tag);
    logic [15:0] oe, dout, ana;
    @(negedge clk_i); #1;
    for (int p = 0; p < 16; p++) begin
      logic [1:0] md;
      logic drv, lvl;
      md     = m_mode[2*p +: 2];
      drv    = (md == 2'b01) || (md == 2'b10);
      lvl    = (md == 2'b10) ? alt_i[p] : m_out[p];
      oe[p]  = drv && (!m_otype[p] || !lvl);
      dout[p] = drv && lvl;
      ana[p] = (md == 2'b11);
    end
    chk({tag, " R9 oe"}, {48'h0, pad_oe_o}, {48'h0, oe});
    chk({tag, " R9 do"}, {48'h0, pad_do_o}, {48'h0, dout});
    chk({tag, " R2 analog"}, {48'h0, pad_analog_o}, {48'h0, ana});
    chk({tag, " R4 speed"}, {32'h0, pad_speed_o}, {32'h0, m_speed});
    chk({tag, " R4 pull"}, {32'h0, pad_pull_o}, {32'h0, m_pull});
    chk({tag, " R5 af"}, pad_af_o, {m_afhi, m_aflo});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m_mode = 0; m_speed = 0; m_pull = 0; m_aflo = 0; m_afhi = 0;
    m_otype = 0; m_out = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1: reset state
    for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R1 reset read");
    chk_pads("R1 reset");

    // R6: set/clear with overlap, set wins; word reads zero
    wr(4'd5, 32'h0000_00F0);
    wr(4'd6, 32'h0F0F_0300);
    rd(4'd5, 32'h0000_03F0, "R6 set/clr mix");
    wr(4'd6, 32'h0001_0001);
    rd(4'd5, 32'h0000_03F1, "R6 set wins");
    wr(4'd6, 32'h0000_0000);
    rd(4'd5, 32'h0000_03F1, "R6 zero no change");
    rd(4'd6, 32'h0, "R6 reads zero");
    // R7: whole write, upper bits dropped
    wr(4'd5, 32'hFFFF_A55A);
    rd(4'd5, 32'h0000_A55A, "R7 whole write");

    // R3/R9: open-drain outputs drive only low
    wr(4'd0, 32'h5555_5555);
    wr(4'd1, 32'hFFFF_00FF);
    rd(4'd1, 32'h0000_00FF, "R3 otype readback");
    wr(4'd5, 32'h0000_0F0F);
    chk_pads("R9 open-drain");
    // R9: alternate function uses alt_i
    alt_i = 16'h3C3C;
    wr(4'd0, 32'hAAAA_AAAA);
    chk_pads("R9 alt");
    // R5: af split
    wr(4'd7, 32'h7654_3210);
    wr(4'd8, 32'hFEDC_BA98);
    chk_pads("R5 af map");
    chk("R5 pin9 af", {60'h0, pad_af_o[39:36]}, 64'h9);

    // R8: two-stage synchronizer latency, writes ignored
    @(negedge clk_i); pin_i = 16'h1234;
    rd(4'd4, 32'h0, "R8 not yet");
    rd(4'd4, 32'h1234, "R8 visible");
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, 32'h1234, "R8 write ignored");

    // R10: unmapped
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd12, 32'h0, "R10 unmapped read");
    chk_pads("R10 unmapped no effect");

    // random mix
    pin_i = 16'hA5C3;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      a = 4'($urandom % 11);
      alt_i = 16'($urandom);
      wr(a, $urandom);
      chk_pads("rand R2 R3 R4 R5 R9");
      a = 4'($urandom % 11);
      rd(a, exp_rd(a), "rand R2 R3 R4 R5 R6 R7 R8 R10 read");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule